// File: doc/BRIEF.md
# Dual-slope symmetric PWM timer

This block is a 16-bit up/down counter that climbs from zero to a programmable turnaround value (TOP) and then falls back to zero, over and over. Each compare channel compares its active value with the counter. On a match, the channel drives its waveform level low while the counter rises and high while it falls. The result is a pulse centred on the counter's lowest point. A per-channel output mode passes that level straight through, inverts it, or forces the pin low.

TOP is taken either from a dedicated period register or from channel 0's compare value, chosen by a select input. Software-side writes land in buffer registers. The buffers are copied into the active registers only when the counter sits at zero. Every period is therefore built from one consistent set of values and stays symmetric, even when the period or a duty value is changed in the middle of a period. Three kinds of sticky event flags are provided: a zero-crossing flag, a period-TOP flag and one compare flag per channel. They are cleared by write-one pulses. The counter moves only on cycles where the tick input is high, so an external prescaler sets the rate.

Top module: `dual_slope_pwm_timer`

## Requirements
- R1: On each tick the counter steps by one. It runs 0,1,…,TOP,TOP-1,…,1,0,1,… and holds TOP and 0 for exactly one tick each, so one period is 2·TOP ticks. `count_down` is 1 when the last step was downward and 0 when it was upward.
- R2: On a cycle where `tick` is 0, `count` and `count_down` keep their values.
- R3: With `top_from_ch0`=0, TOP is the active period value. With `top_from_ch0`=1, TOP is channel 0's active compare value. The select input is sampled at the zero point. Any TOP value below 3 acts as 3, and the all-ones value gives the full counter range.
- R4: Buffer writes (`per_wr`, `cmp_wr[i]`) take effect only on a tick cycle in which `count` is 0. On that edge every active value is loaded from its buffer, and the TOP select is sampled. A buffer write issued in that same cycle waits for the next zero point.
- R5: Flag bit 0 (zero flag) is set after every tick cycle in which `count` is 0.
- R6: Flag bit 1 (period-TOP flag) is set after a tick cycle in which `count` equals TOP, but only while TOP comes from the period register.
- R7: Flag bit 2+i is set after every tick cycle in which `count` equals channel i's active compare value.
- R8: A channel's internal level becomes 0 on a match reached by an upward step and 1 on a match reached by a downward step. Output mode 2 drives the level on `pwm_out[i]` and mode 3 drives its inverse, each one clock after the level changes. Mode bits for channel i are `out_mode[2i+1:2i]`.
- R9: Output modes 0 and 1 drive `pwm_out[i]` low.
- R10: Flags are sticky. A 1 on `flag_clr[k]` clears flag k on the next edge, unless flag k is set in that same cycle, in which case the set wins.
- R11: Synchronous reset sets `count` to 0 and the direction to up. It drives all outputs and flags low, sets the active and buffered period to all ones and sets compare values to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable from a prescaler |
| top_from_ch0 | input | 1 | 1: TOP from channel 0 compare, 0: from period register |
| per_wr | input | 1 | Write strobe for the period buffer |
| per_data | input | CNT_W | Period buffer write data |
| cmp_wr | input | NCH | Per-channel compare buffer write strobes |
| cmp_data | input | NCH·CNT_W | Compare write data, channel i in bits [i·CNT_W +: CNT_W] |
| out_mode | input | 2·NCH | Per-channel output mode |
| flag_clr | input | NCH+2 | Write-one-to-clear per flag |
| count | output | CNT_W | Counter value |
| count_down | output | 1 | Direction of the last step |
| pwm_out | output | NCH | Channel waveform outputs |
| flags | output | NCH+2 | Sticky flags: zero, period TOP, compare per channel |

## Verification
The bench builds the timer with a 10-bit counter and three channels. The narrower counter brings the all-ones TOP, a 2046-tick period, within a short run beside many small-period runs. The third channel exercises the generated channel path beyond channel 0's dual role as TOP source. Small random TOP values near the clamp floor, together with compare values above TOP, at zero and at TOP, reach the coincident-event cases. Mid-period buffer writes show the deferred load.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [1:0] {
    OM_OFF    = 2'd0,
    OM_RSVD   = 2'd1,
    OM_NONINV = 2'd2,
    OM_INV    = 2'd3
  } out_mode_e;

  localparam int MIN_TOP = 3;

  // Level taken on a match: high when reached going down, low going up.
  function automatic logic match_level(input logic moving_down);
    match_level = moving_down;
  endfunction

  // Map the raw waveform level to the pin according to the output mode.
  function automatic logic shape_out(input logic [1:0] mode, input logic lvl);
    case (out_mode_e'(mode))
      OM_NONINV: shape_out = lvl;
      OM_INV:    shape_out = ~lvl;
      default:   shape_out = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] count,
  output logic             down,
  output logic             at_bottom,
  output logic             at_top
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  logic             down_q;
  logic             turn_down;
  logic             turn_up;
  logic             dir_next;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v,
                                            input logic dn);
    step = dn ? v - 1'b1 : v + 1'b1;
  endfunction

  assign turn_down = !down_q && (cnt_q >= top);
  assign turn_up   = down_q && (cnt_q == ZERO);

  always_comb begin
    if (turn_down)    dir_next = 1'b1;
    else if (turn_up) dir_next = 1'b0;
    else              dir_next = down_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= ZERO;
      down_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= step(cnt_q, dir_next);
      down_q <= dir_next;
    end
  end

  assign at_bottom = tick && (cnt_q == ZERO);
  assign at_top    = tick && (cnt_q == top);
  assign count     = cnt_q;
  assign down      = down_q;
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCH   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 top_from_ch0,
  input  logic                 per_wr,
  input  logic [CNT_W-1:0]     per_data,
  input  logic [NCH-1:0]       cmp_wr,
  input  logic [NCH*CNT_W-1:0] cmp_data,
  output logic [NCH*CNT_W-1:0] cmp_act,
  output logic [CNT_W-1:0]     top_act,
  output logic                 src_ch0
);
  localparam logic [CNT_W-1:0] ONES      = '1;
  localparam logic [CNT_W-1:0] ZERO      = '0;
  localparam logic [CNT_W-1:0] MIN_TOP_V = CNT_W'(MIN_TOP);

  logic [CNT_W-1:0] per_buf;
  logic [CNT_W-1:0] per_act;
  logic             src_q;

  function automatic logic [CNT_W-1:0] clamp_top(input logic [CNT_W-1:0] v);
    clamp_top = (v < MIN_TOP_V) ? MIN_TOP_V : v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      per_buf <= ONES;
      per_act <= ONES;
      src_q   <= 1'b0;
    end else begin
      if (load) begin
        per_act <= per_buf;
        src_q   <= top_from_ch0;
      end
      if (per_wr) per_buf <= per_data;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    logic [CNT_W-1:0] buf_q;
    logic [CNT_W-1:0] act_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        buf_q <= ZERO;
        act_q <= ZERO;
      end else begin
        if (load)      act_q <= buf_q;
        if (cmp_wr[i]) buf_q <= cmp_data[i*CNT_W +: CNT_W];
      end
    end
    assign cmp_act[i*CNT_W +: CNT_W] = act_q;
  end

  assign top_act = clamp_top(src_q ? cmp_act[CNT_W-1:0] : per_act);
  assign src_ch0 = src_q;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic             down,
  input  logic [CNT_W-1:0] cmp,
  input  logic [1:0]       mode,
  output logic             hit,
  output logic             pwm
);
  logic lvl_q;
  logic lvl_d;
  logic pwm_q;

  assign hit   = tick && (count == cmp);
  assign lvl_d = hit ? match_level(down) : lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      pwm_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      pwm_q <= shape_out(mode, lvl_d);
    end
  end

  assign pwm = pwm_q;
endmodule

// File: rtl/dual_slope_pwm_timer.sv
module dual_slope_pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCH   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 top_from_ch0,
  input  logic                 per_wr,
  input  logic [CNT_W-1:0]     per_data,
  input  logic [NCH-1:0]       cmp_wr,
  input  logic [NCH*CNT_W-1:0] cmp_data,
  input  logic [2*NCH-1:0]     out_mode,
  input  logic [NCH+1:0]       flag_clr,
  output logic [CNT_W-1:0]     count,
  output logic                 count_down,
  output logic [NCH-1:0]       pwm_out,
  output logic [NCH+1:0]       flags
);
  localparam int NFLAG = NCH + 2;

  // Named internal events, observed by the bound checker.
  logic                 ev_bottom;
  logic                 ev_top;
  logic [NCH-1:0]       ev_match;
  logic [CNT_W-1:0]     top_act;
  logic                 src_ch0;
  logic [NCH*CNT_W-1:0] cmp_act;
  logic [NFLAG-1:0]     flag_set;
  logic [NFLAG-1:0]     flag_q;

  pwm_updown_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .top       (top_act),
    .count     (count),
    .down      (count_down),
    .at_bottom (ev_bottom),
    .at_top    (ev_top)
  );

  pwm_shadow_regs #(.CNT_W(CNT_W), .NCH(NCH)) u_shadow (
    .clk          (clk),
    .rst          (rst),
    .load         (ev_bottom),
    .top_from_ch0 (top_from_ch0),
    .per_wr       (per_wr),
    .per_data     (per_data),
    .cmp_wr       (cmp_wr),
    .cmp_data     (cmp_data),
    .cmp_act      (cmp_act),
    .top_act      (top_act),
    .src_ch0      (src_ch0)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk   (clk),
      .rst   (rst),
      .tick  (tick),
      .count (count),
      .down  (count_down),
      .cmp   (cmp_act[i*CNT_W +: CNT_W]),
      .mode  (out_mode[2*i +: 2]),
      .hit   (ev_match[i]),
      .pwm   (pwm_out[i])
    );
  end

  assign flag_set[0]         = ev_bottom;
  assign flag_set[1]         = ev_top && !src_ch0;
  assign flag_set[NFLAG-1:2] = ev_match;

  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flag_q[k] <= 1'b0;
      else     flag_q[k] <= flag_set[k] | (flag_q[k] & ~flag_clr[k]);
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int CNT_W = 16,
  parameter int NCH   = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 tick,
  input logic [CNT_W-1:0]     count,
  input logic                 count_down,
  input logic [CNT_W-1:0]     top_act,
  input logic                 src_ch0,
  input logic                 ev_bottom,
  input logic                 ev_top,
  input logic [NCH-1:0]       ev_match,
  input logic [2*NCH-1:0]     out_mode,
  input logic [NCH+1:0]       flag_clr,
  input logic [NCH+1:0]       flags,
  input logic [NCH-1:0]       pwm_out
);
  assert_step_one_R1: assert property (@(posedge clk) disable iff (rst)
    tick |=> (count == $past(count) + 1'b1) || (count == $past(count) - 1'b1));

  assert_top_bound_R1: assert property (@(posedge clk) disable iff (rst)
    count <= top_act);

  assert_turn_at_top_R1: assert property (@(posedge clk) disable iff (rst)
    ev_top |=> count_down);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count) && $stable(count_down));

  assert_shadow_stable_R4: assert property (@(posedge clk) disable iff (rst)
    !ev_bottom |=> $stable(top_act));

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (rst)
    ev_bottom |=> flags[0]);

  assert_top_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_top && !src_ch0) |=> flags[1]);

  for (genvar i = 0; i < NCH; i++) begin : g_chk_ch
    assert_match_flag_R7: assert property (@(posedge clk) disable iff (rst)
      ev_match[i] |=> flags[2+i]);
    assert_off_low_R9: assert property (@(posedge clk) disable iff (rst)
      !out_mode[2*i+1] |=> !pwm_out[i]);
  end

  for (genvar k = 0; k < NCH + 2; k++) begin : g_chk_flag
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
      (flags[k] && !flag_clr[k]) |=> flags[k]);
  end
endmodule

bind dual_slope_pwm_timer pwm_timer_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .count      (count),
  .count_down (count_down),
  .top_act    (top_act),
  .src_ch0    (src_ch0),
  .ev_bottom  (ev_bottom),
  .ev_top     (ev_top),
  .ev_match   (ev_match),
  .out_mode   (out_mode),
  .flag_clr   (flag_clr),
  .flags      (flags),
  .pwm_out    (pwm_out)
);

// File: tb/sim_dual_slope_pwm_timer.sv
module sim_dual_slope_pwm_timer;
  localparam int W  = 10;
  localparam int NC = 3;
  localparam int NF = NC + 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              b_rst = 1'b1;
  logic              b_tick = 1'b0;
  logic              b_sel = 1'b0;
  logic              b_per_wr = 1'b0;
  logic [W-1:0]      b_per_data = '0;
  logic [NC-1:0]     b_cmp_wr = '0;
  logic [NC*W-1:0]   b_cmp_data = '0;
  logic [2*NC-1:0]   b_mode = '0;
  logic [NF-1:0]     b_clr = '0;

  logic [W-1:0]      count;
  logic              count_down;
  logic [NC-1:0]     pwm_out;
  logic [NF-1:0]     flags;

  dual_slope_pwm_timer #(.CNT_W(W), .NCH(NC)) u0 (
    .clk(clk), .rst(b_rst), .tick(b_tick), .top_from_ch0(b_sel),
    .per_wr(b_per_wr), .per_data(b_per_data), .cmp_wr(b_cmp_wr),
    .cmp_data(b_cmp_data), .out_mode(b_mode), .flag_clr(b_clr),
    .count(count), .count_down(count_down), .pwm_out(pwm_out), .flags(flags)
  );

  int n_checks = 0;
  int n_err = 0;
  int cyc = 0;
  bit chk_on = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_cnt, m_down, m_per_buf, m_per_act, m_sel;
  int m_cmp_buf[NC];
  int m_cmp_act[NC];
  int m_lvl[NC];
  int m_pwm[NC];
  logic [NF-1:0] m_flags;

  function automatic int eff_top(input int v);
    return (v < 3) ? 3 : v;
  endfunction

  function automatic int pin_of(input int mode, input int lvl);
    if (mode == 3) return 1 - lvl;
    if (mode == 2) return lvl;
    return 0;
  endfunction

  always @(posedge clk) begin
    int t;
    logic [NF-1:0] f;
    bit at_zero;
    if (b_rst) begin
      m_cnt = 0; m_down = 0; m_per_buf = (1 << W) - 1; m_per_act = (1 << W) - 1;
      m_sel = 0; m_flags = '0;
      for (int i = 0; i < NC; i++) begin
        m_cmp_buf[i] = 0; m_cmp_act[i] = 0; m_lvl[i] = 0; m_pwm[i] = 0;
      end
    end else begin
      t = m_sel ? eff_top(m_cmp_act[0]) : eff_top(m_per_act);
      f = m_flags & ~b_clr;
      at_zero = (m_cnt == 0);
      if (b_tick) begin
        if (at_zero) f[0] = 1'b1;
        if (m_cnt == t && m_sel == 0) f[1] = 1'b1;
        for (int i = 0; i < NC; i++)
          if (m_cnt == m_cmp_act[i]) begin
            f[2+i] = 1'b1;
            m_lvl[i] = m_down;
          end
        if (m_down == 0 && m_cnt == t) m_down = 1;
        else if (m_down == 1 && m_cnt == 0) m_down = 0;
        m_cnt = m_down ? m_cnt - 1 : m_cnt + 1;
        if (at_zero) begin
          m_per_act = m_per_buf;
          m_sel = b_sel;
          for (int i = 0; i < NC; i++) m_cmp_act[i] = m_cmp_buf[i];
        end
      end
      if (b_per_wr) m_per_buf = b_per_data;
      for (int i = 0; i < NC; i++) begin
        if (b_cmp_wr[i]) m_cmp_buf[i] = b_cmp_data[i*W +: W];
        m_pwm[i] = pin_of(b_mode[2*i +: 2], m_lvl[i]);
      end
      m_flags = f;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R1 count", count, m_cnt);
      chk("R1 direction", count_down, m_down);
      chk("R5 zero flag", flags[0], m_flags[0]);
      chk("R6 top flag", flags[1], m_flags[1]);
      for (int i = 0; i < NC; i++) begin
        chk("R7 compare flag", flags[2+i], m_flags[2+i]);
        chk("R8 pwm pin", pwm_out[i], m_pwm[i]);
      end
    end
  end

  // ---------------- helpers (called right after a negedge) ----------------
  task automatic wr_per(input int v);
    b_per_wr = 1'b1; b_per_data = W'(v);
    @(negedge clk);
    b_per_wr = 1'b0;
  endtask

  task automatic wr_cmp(input int ch, input int v);
    b_cmp_wr[ch] = 1'b1; b_cmp_data[ch*W +: W] = W'(v);
    @(negedge clk);
    b_cmp_wr = '0;
  endtask

  task automatic peak_to_zero(output int peak);
    peak = count;
    while (count != 0) begin
      @(negedge clk);
      if (count > peak) peak = count;
    end
  endtask

  task automatic measure_period(output int peak, output int len);
    while (count != 0) @(negedge clk);
    peak = 0; len = 0;
    do begin
      @(negedge clk);
      len++;
      if (count > peak) peak = count;
    end while (count != 0);
  endtask

  task automatic count_high(input int ch, input int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_checks++; n_err++;
      $display("FAIL watchdog R1 actual %0d expected %0d", cyc, 100000);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int pk, ln, hi, hold;
    void'($urandom(32'h5EED_0042));
    b_mode = {3{2'd3}};
    repeat (3) @(negedge clk);
    // R11: outputs low during reset even with the inverting mode selected
    chk("R11 pwm in reset", pwm_out, 0);
    chk("R11 count in reset", count, 0);
    chk("R11 dir in reset", count_down, 0);
    chk("R11 flags in reset", flags, 0);
    b_rst = 1'b0;
    chk_on = 1'b1;
    b_mode = {2'd1, 2'd3, 2'd2};
    wr_per(20);
    wr_cmp(0, 8);
    wr_cmp(1, 14);
    wr_cmp(2, 5);
    repeat (8) @(negedge clk);
    chk("R2 idle count", count, 0);
    chk("R2 idle flags", flags, 0);
    b_tick = 1'b1;
    measure_period(pk, ln);
    chk("R3 period source peak", pk, 20);
    chk("R1 period length", ln, 40);
    count_high(0, 40, hi);
    chk("R8 non-inverting high ticks", hi, 16);
    count_high(1, 40, hi);
    chk("R8 inverting high ticks", hi, 12);
    count_high(2, 40, hi);
    chk("R9 reserved mode stays low", hi, 0);
    b_mode[5:4] = 2'd0;
    count_high(2, 40, hi);
    chk("R9 off mode stays low", hi, 0);

    // R2: hold mid-period
    @(negedge clk);
    hold = count;
    b_tick = 1'b0;
    repeat (15) @(negedge clk);
    chk("R2 hold count", count, hold);
    b_tick = 1'b1;

    // R4: mid-period period write waits for zero
    while (!(count == 5 && !count_down)) @(negedge clk);
    wr_per(30);
    peak_to_zero(pk);
    chk("R4 old period kept", pk, 20);
    measure_period(pk, ln);
    chk("R4 new period peak", pk, 30);
    chk("R4 new period length", ln, 60);

    // R3: TOP from channel 0
    b_sel = 1'b1;
    wr_cmp(0, 15);
    peak_to_zero(pk);
    measure_period(pk, ln);
    chk("R3 channel source peak", pk, 15);
    chk("R3 channel source length", ln, 30);
    b_clr = '1;
    @(negedge clk);
    b_clr = '0;
    measure_period(pk, ln);
    chk("R6 no period flag with channel source", flags[1], 0);
    chk("R7 channel 0 flag at TOP", flags[2], 1);

    // R3: clamp to 3
    b_sel = 1'b0;
    wr_per(1);
    peak_to_zero(pk);
    measure_period(pk, ln);
    chk("R3 clamped peak", pk, 3);
    chk("R3 clamped length", ln, 6);

    // R10: clear and set-wins
    while (count != 3) @(negedge clk);
    chk("R5 zero flag present", flags[0], 1);
    b_clr = 5'b00001;
    @(negedge clk);
    b_clr = '0;
    chk("R10 clear works", flags[0], 0);
    while (count != 0) @(negedge clk);
    b_clr = 5'b00001;
    @(negedge clk);
    b_clr = '0;
    chk("R10 set wins over clear", flags[0], 1);

    // R3: full-range TOP
    wr_per((1 << W) - 1);
    peak_to_zero(pk);
    measure_period(pk, ln);
    chk("R3 full range peak", pk, (1 << W) - 1);
    chk("R1 full range length", ln, 2 * ((1 << W) - 1));

    // random mix, checked by the model every cycle (R1..R10)
    wr_per(12);
    for (int n = 0; n < 5000; n++) begin
      b_tick = ($urandom % 4) != 0;
      if ($urandom % 40 == 0) begin
        b_per_wr = 1'b1; b_per_data = W'($urandom % 50);
      end
      for (int i = 0; i < NC; i++)
        if ($urandom % 40 == 0) begin
          b_cmp_wr[i] = 1'b1; b_cmp_data[i*W +: W] = W'($urandom % 56);
        end
      if ($urandom % 200 == 0) b_sel = ~b_sel;
      if ($urandom % 100 == 0) b_mode = 6'($urandom);
      b_clr = ($urandom % 16 == 0) ? NF'($urandom) : '0;
      @(negedge clk);
      b_per_wr = 1'b0; b_cmp_wr = '0; b_clr = '0;
    end
    finish_run();
  end
endmodule